// File: doc/BRIEF.md
# BCH(31,21) Serial Decoder with Double-Error Correction

This block takes one 31-bit received word of a double-error-correcting (31,21) BCH code, one bit per accepted cycle. As the bits arrive, two 5-bit remainder registers divide the word by the two minimal polynomials. The first remainder is the syndrome S1. The second remainder is evaluated at alpha cubed to give S3. The decoder works in GF(32), built on x^5+x^2+1.

When the last bit is in, one cycle solves for the error-locator polynomial. A 31-step root search then marks every bit position where the polynomial vanishes. The block flips the marked bits and presents the 21 data bits with a one-cycle valid pulse. A 2-bit status goes with the data and tells the receiver how much was repaired.

A word starts with a strobe that comes together with its first bit. While a word is being decoded, the block ignores its inputs. The receiver must therefore wait for the result before it sends the next word.

Top module: `bch3121_dec`

## Requirements
- R1: While reset is asserted and after it is released, out_valid is low, out_data is zero and out_status is zero.
- R2: Bits arrive first-to-last as coefficients x^30 down to x^0. The first 21 bits are the data, and out_data[20] is the first bit. A word that is a multiple of x^10+x^9+x^8+x^6+x^5+x^3+1 gives status 2'b00 and its data unchanged.
- R3: A single flipped bit at any of the 31 positions is corrected, and the status is 2'b01.
- R4: Any two flipped bits are corrected, and the status is 2'b10.
- R5: A word with S1 zero and S3 nonzero is reported with status 2'b11. The same status is given when the number of roots found does not match the degree of the locator. With status 2'b11, out_data carries the first 21 received bits uncorrected.
- R6: When start and bit_valid are high together, a new word begins with that bit and any partial word is discarded. A start without bit_valid has no effect.
- R7: From the 31st accepted bit until the result pulse, bit_valid, bit_in and start are ignored.
- R8: Each complete word gives exactly one out_valid pulse, one cycle wide, no later than 40 cycles after its last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Marks the accompanying bit as the first bit of a word |
| bit_valid | input | 1 | bit_in carries a code bit this cycle |
| bit_in | input | 1 | Serial code bit, highest coefficient first |
| out_valid | output | 1 | One-cycle pulse: out_data and out_status are valid |
| out_data | output | 21 | Corrected data bits, first received bit in bit 20 |
| out_status | output | 2 | 00 clean, 01 one fixed, 10 two fixed, 11 uncorrectable |

## Verification
Clean codewords are sent with all-zero, all-one, alternating and pseudo-random data. These show that the bit order is right and that no false correction happens. A single error is swept across all 31 positions, which covers both the S3 = S1^3 path and the complete position mapping of the root search. Error pairs are placed at the two ends of the word, across the data/parity boundary and on adjacent bits, which exercises the degree-2 solve. Patterns equal to a shifted copy of x^5+x^2+1 give S1 = 0 with S3 nonzero; the copy placed inside the data field separates "raw data passed through" from any attempted fix. Truncated words and junk input sent while decoding is busy show that restart works and that busy input is ignored.

// File: rtl/bch3121_dec.sv
`timescale 1ns/1ps
module bch3121_dec (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        bit_valid,
  input  logic        bit_in,
  output logic        out_valid,
  output logic [20:0] out_data,
  output logic [1:0]  out_status
);
  localparam int NBITS = 31;
  localparam int KBITS = 21;
  localparam int PBITS = NBITS - KBITS;
  localparam logic [5:0] MASK1 = 6'h25;
  localparam logic [5:0] MASK3 = 6'h3D;

  typedef enum logic [2:0] {IDLE, COLL, SOLVE, SRCH, DONE} st_t;
  st_t state;

  logic [4:0] bcnt, m1, m3, sg1, sg2, t1, t2, k, s3, sig2_n, pos;
  logic [30:0] rx, errv, fixed;
  logic [1:0] nroot, st_n;
  logic zflag, root;

  function automatic logic [4:0] xa(input logic [4:0] a);
    return a[4] ? ({a[3:0], 1'b0} ^ 5'h05) : {a[3:0], 1'b0};
  endfunction

  function automatic logic [4:0] gmul(input logic [4:0] a, input logic [4:0] b);
    logic [4:0] p, aa;
    p = '0;
    aa = a;
    for (int i = 0; i < 5; i++) begin
      if (b[i]) p = p ^ aa;
      aa = xa(aa);
    end
    return p;
  endfunction

  function automatic logic [4:0] ginv(input logic [4:0] a);
    logic [4:0] p, sq;
    p = 5'd1;
    sq = a;
    for (int i = 1; i < 5; i++) begin
      sq = gmul(sq, sq);
      p = gmul(p, sq);
    end
    return p;
  endfunction

  function automatic logic [4:0] apow(input int n);
    logic [4:0] p;
    p = 5'd1;
    for (int i = 0; i < NBITS; i++)
      if (i < n) p = xa(p);
    return p;
  endfunction

  function automatic logic [4:0] divstep(input logic [4:0] r, input logic b, input logic [5:0] mask);
    logic [5:0] t;
    t = {r, b};
    return t[5] ? (t[4:0] ^ mask[4:0]) : t[4:0];
  endfunction

  always_comb begin
    s3 = '0;
    for (int i = 0; i < 5; i++)
      if (m3[i]) s3 = s3 ^ apow(3 * i);
    sig2_n = gmul(s3, ginv(m1)) ^ gmul(m1, m1);
  end

  assign root  = (5'd1 ^ t1 ^ t2) == 5'd0;
  assign pos   = (k == 5'd0) ? 5'd0 : 5'd31 - k;
  assign fixed = rx ^ errv;

  always_comb begin
    if (zflag)                                       st_n = 2'd0;
    else if (sg2 != 5'd0 && nroot == 2'd2)           st_n = 2'd2;
    else if (sg2 == 5'd0 && nroot == 2'd1)           st_n = 2'd1;
    else                                             st_n = 2'd3;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE;
      bcnt <= '0; m1 <= '0; m3 <= '0; rx <= '0; errv <= '0;
      sg1 <= '0; sg2 <= '0; t1 <= '0; t2 <= '0; k <= '0;
      nroot <= '0; zflag <= 1'b0;
      out_valid <= 1'b0; out_data <= '0; out_status <= '0;
    end else begin
      out_valid <= 1'b0;
      case (state)
        IDLE, COLL: begin
          if (bit_valid && start) begin
            m1 <= divstep(5'd0, bit_in, MASK1);
            m3 <= divstep(5'd0, bit_in, MASK3);
            rx <= {30'd0, bit_in};
            bcnt <= 5'd1;
            state <= COLL;
          end else if (bit_valid && state == COLL) begin
            m1 <= divstep(m1, bit_in, MASK1);
            m3 <= divstep(m3, bit_in, MASK3);
            rx <= {rx[29:0], bit_in};
            bcnt <= bcnt + 5'd1;
            if (bcnt == 5'(NBITS - 1)) state <= SOLVE;
          end
        end
        SOLVE: begin
          sg1 <= m1;
          sg2 <= sig2_n;
          t1 <= m1;
          t2 <= sig2_n;
          zflag <= (m1 == 5'd0) && (s3 == 5'd0);
          errv <= '0;
          nroot <= '0;
          k <= '0;
          state <= SRCH;
        end
        SRCH: begin
          if (root) begin
            errv[pos] <= 1'b1;
            nroot <= nroot + {1'b0, nroot != 2'd3};
          end
          t1 <= xa(t1);
          t2 <= xa(xa(t2));
          k <= k + 5'd1;
          if (k == 5'(NBITS - 1)) state <= DONE;
        end
        default: begin
          out_valid <= 1'b1;
          out_status <= st_n;
          out_data <= (st_n == 2'd3) ? rx[NBITS-1:PBITS] : fixed[NBITS-1:PBITS];
          state <= IDLE;
        end
      endcase
    end
  end

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  a_r2_clean_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_status == 2'd0 |-> out_data == rx[NBITS-1:PBITS] && errv == '0);
  a_r3_one_flip: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_status == 2'd1 |-> $countones(errv) == 1);
  a_r4_two_flips: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_status == 2'd2 |-> $countones(errv) == 2);
  a_r5_raw_data: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_status == 2'd3 |-> out_data == rx[NBITS-1:PBITS]);
  a_r7_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    state == SRCH && bit_valid && start |=> state == SRCH || state == DONE);
endmodule

// File: tb/bch3121_dec_bench.sv
`timescale 1ns/1ps
module bch3121_dec_bench;
  logic clk = 0, rst_n = 0, start = 0, bit_valid = 0, bit_in = 0;
  logic out_valid;
  logic [20:0] out_data;
  logic [1:0] out_status;
  int checks = 0, failures = 0, cycles = 0;
  logic [22:0] q[$];
  string tq[$];
  logic [31:0] lf = 32'h1234_5678;
  logic prev_valid = 0;

  always #4 clk = ~clk;

  bch3121_dec u_bch3121_dec (.clk(clk), .rst_n(rst_n), .start(start), .bit_valid(bit_valid),
    .bit_in(bit_in), .out_valid(out_valid), .out_data(out_data), .out_status(out_status));

  function automatic logic [30:0] enc(input logic [20:0] d);
    logic [30:0] r;
    r = {d, 10'b0};
    for (int i = 30; i >= 10; i--)
      if (r[i]) r = r ^ (31'h769 << (i - 10));
    return {d, r[9:0]};
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (prev_valid) begin
        failures++;
        $display("FAIL R8 pulse wider than one cycle: actual 2+ expected 1");
      end
      if (q.size() == 0) begin
        failures++;
        $display("FAIL R8 unexpected output: actual data=%h status=%0d expected none", out_data, out_status);
      end else begin
        logic [22:0] e;
        string t;
        e = q.pop_front();
        t = tq.pop_front();
        if ({out_data, out_status} !== e) begin
          failures++;
          $display("FAIL %s: actual data=%h status=%0d expected data=%h status=%0d",
                   t, out_data, out_status, e[22:2], e[1:0]);
        end
      end
    end
    prev_valid = out_valid;
  end

  task automatic send(input logic [20:0] d, input logic [30:0] err, input logic [1:0] st,
                      input string tag, input bit junk);
    logic [30:0] w;
    int c;
    w = enc(d) ^ err;
    q.push_back({(st == 2'd3) ? w[30:10] : d, st});
    tq.push_back(tag);
    for (int i = 0; i < 31; i++) begin
      @(negedge clk);
      bit_valid = 1; start = (i == 0); bit_in = w[30 - i];
    end
    @(negedge clk);
    bit_valid = 0; start = 0;
    for (c = 0; c < 60 && q.size() != 0; c++) begin
      if (junk && c < 20) begin
        lf = nxt(lf);
        bit_valid = 1; start = lf[3]; bit_in = lf[7];
      end else begin
        bit_valid = 0; start = 0;
      end
      @(negedge clk);
      #1;
    end
    bit_valid = 0; start = 0;
    checks++;
    if (c > 40) begin
      failures++;
      $display("FAIL R8 latency: actual %0d expected <=40", c);
    end
  endtask

  task automatic partial(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lf = nxt(lf);
      bit_valid = 1; start = (i == 0); bit_in = lf[5];
    end
    @(negedge clk);
    bit_valid = 0; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 0 || out_data !== 0 || out_status !== 0) begin
      failures++;
      $display("FAIL R1 reset: actual %b/%h/%0d expected 0/0/0", out_valid, out_data, out_status);
    end
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (out_valid !== 0 || out_data !== 0 || out_status !== 0) begin
      failures++;
      $display("FAIL R1 after reset: actual %b/%h/%0d expected 0/0/0", out_valid, out_data, out_status);
    end

    send(21'h000000, 31'd0, 2'd0, "R2 clean zero", 0);
    send(21'h1FFFFF, 31'd0, 2'd0, "R2 clean ones", 0);
    send(21'h155555, 31'd0, 2'd0, "R2 clean alt", 0);
    send(21'h0AAAAA, 31'd0, 2'd0, "R2 clean alt2", 0);
    send(21'h100001, 31'd0, 2'd0, "R2 clean ends", 0);

    for (int p = 0; p < 31; p++) begin
      lf = nxt(lf);
      send(lf[20:0], 31'd1 << p, 2'd1, $sformatf("R3 single at %0d", p), 0);
    end

    send(21'h0F0F0F, (31'd1 << 30) | 31'd1, 2'd2, "R4 pair 30,0", 0);
    send(21'h123456, (31'd1 << 29) | (31'd1 << 10), 2'd2, "R4 pair 29,10", 0);
    send(21'h1ABCDE, (31'd1 << 10) | (31'd1 << 9), 2'd2, "R4 pair 10,9", 0);
    send(21'h000000, (31'd1 << 15) | (31'd1 << 3), 2'd2, "R4 pair 15,3", 0);
    send(21'h1FFFFF, (31'd1 << 21) | (31'd1 << 20), 2'd2, "R4 pair 21,20", 0);
    for (int p = 1; p < 31; p += 4) begin
      lf = nxt(lf);
      send(lf[20:0], (31'd1 << p) | (31'd1 << (p - 1)), 2'd2, $sformatf("R4 adjacent %0d", p), 0);
    end

    send(21'h13579B, 31'h25, 2'd3, "R5 S1 zero low", 0);
    send(21'h02468A, 31'h4A, 2'd3, "R5 S1 zero shifted", 0);
    send(21'h0C3C3C, 31'h25 << 12, 2'd3, "R5 raw data field", 0);

    partial(12);
    send(21'h0DEAD1, 31'd1 << 7, 2'd1, "R6 restart after partial", 0);
    partial(30);
    send(21'h155AA5, 31'd0, 2'd0, "R6 restart after 30 bits", 0);

    send(21'h1C0FFE, (31'd1 << 25) | (31'd1 << 4), 2'd2, "R7 junk while busy", 1);
    send(21'h0BEEF0, 31'd0, 2'd0, "R7 next word after junk", 0);

    repeat (50) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      failures++;
      $display("FAIL R8 missing outputs: actual %0d pending expected 0", q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule